// File: doc/BRIEF.md
# Dual-Mode Barrel Shifter with Leading-Digit Normalizer

This block is a purely combinational word shifter. It has one shift array and a leading-digit encoder beside it. The array takes a `DATA_W`-bit word and forms a full-width result. That result is either a circular rotation or a linear shift. A linear shift fills its vacated positions with zero when shifting left, or with a supplied sign bit when shifting right. A half-select picks which half of the result drives the `DATA_W/2` output lines. An output enable forces those lines to zero when it is low.

The shift code is always read as a left shift distance. A right shift is asked for by raising the direction bit. The direction bit then acts as the sign bit of a code one bit wider than the shift code. The magnitude of that negative code is the right shift distance, from 1 up to the full word width.

The encoder first inverts the input word when the sign input is high. It then reports how many left shifts would bring the first 1 to the top bit. A normalize select feeds that code straight back as the shift amount. With fill mode and a left shift, this normalizes a mantissa in one pass, whether it is held as sign-magnitude or as two's complement.

Top module: `bsn_shift_norm`

## Requirements
- R1: With `fill_en_i`=0 (wrap), the result is `data_i` rotated left by the shift amount. For example, amount 1 moves input bit `DATA_W-1` to result bit 0, and amount all-ones is a rotate right by one place.
- R2: With `fill_en_i`=0, the value of `dir_right_i` has no effect on `y_o`.
- R3: With `fill_en_i`=1 and `dir_right_i`=0, the result is `data_i` shifted left by the amount (0 to `DATA_W-1` places), and the vacated low bits are 0.
- R4: With `fill_en_i`=1 and `dir_right_i`=1, the result is `data_i` shifted right by `DATA_W` minus the amount (1 to `DATA_W` places), and the vacated high bits equal `sign_i`. Amount 0 gives a result whose every bit equals `sign_i`.
- R5: `upper_sel_i`=1 puts result bits `DATA_W-1:DATA_W/2` on `y_o`, and `upper_sel_i`=0 puts result bits `DATA_W/2-1:0` there.
- R6: `lead_code_o` equals `DATA_W-1` minus the index of the highest set bit of `data_i` XOR `{DATA_W{sign_i}}`. For example, with `DATA_W`=32, a top bit gives 0, bit 15 gives 16, and bit 0 gives 31.
- R7: When `data_i` XOR `{DATA_W{sign_i}}` is all zeros, `lead_code_o` is all ones.
- R8: `sign_i` acts on the shift array only as the right-shift fill value. The array always shifts the raw `data_i`.
- R9: With `norm_i`=1, `lead_code_o` replaces `shamt_i` as the shift amount. With `norm_i`=0, `shamt_i` is the shift amount.
- R10: With `out_en_i`=0, `y_o` is zero. `lead_code_o` stays valid whatever the value of `out_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_i | input | DATA_W | Word to shift and to encode |
| sign_i | input | 1 | Fill value for right shifts; inverts the encoder input when high |
| shamt_i | input | CODE_W | Left-oriented shift code |
| dir_right_i | input | 1 | Direction bit, sign of the extended code; used only in fill mode |
| fill_en_i | input | 1 | 1 = linear shift with fill, 0 = rotate |
| norm_i | input | 1 | 1 = use the encoder code as the shift amount |
| upper_sel_i | input | 1 | 1 = upper result half to output, 0 = lower half |
| out_en_i | input | 1 | 0 forces `y_o` to zero |
| y_o | output | DATA_W/2 | Selected half of the shifted result |
| lead_code_o | output | CODE_W | Left shifts needed to bring the leading digit to the top bit |

## Verification
The bench builds one copy with `DATA_W`=8, which gives a 3-bit code and 4 output lines. Every combination of data word, sign, code, direction, fill/wrap, normalize, half-select and enable is applied to that copy: 131072 vectors, each compared with an arithmetic model. A second copy at the default `DATA_W`=32 gets directed vectors. These cover the wide-word cases: right shift by the full width, encoder codes around the half boundary, the all-zero encoder input in both sign polarities, and single-pass normalization of a word whose leading digit is far down.

// File: rtl/bsn_pkg.sv
package bsn_pkg;

   // How the shift array treats positions that the rotation leaves behind
   typedef enum logic [1:0] {
      FMT_WRAP  = 2'd0,
      FMT_LEFT  = 2'd1,
      FMT_RIGHT = 2'd2
   } shift_fmt_e;

   function automatic shift_fmt_e fmt_of(input logic fill_en, input logic dir_right);
      if (!fill_en)
         return FMT_WRAP;
      else if (dir_right)
         return FMT_RIGHT;
      else
         return FMT_LEFT;
   endfunction

endpackage

// File: rtl/bsn_lead_enc.sv
module bsn_lead_enc #(
   parameter int DATA_W = 32,
   parameter int CODE_W = 5
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic              sign_i,
   output logic [CODE_W-1:0] code_o
);

   localparam logic [CODE_W-1:0] CODE_MAX = CODE_W'(DATA_W - 1);

   if ((1 << CODE_W) != DATA_W) begin : g_bad_width
      $error("bsn_lead_enc: DATA_W must equal 2**CODE_W");
   end

   logic [DATA_W-1:0] srch;

   assign srch = data_i ^ {DATA_W{sign_i}};

   // Scan from the bottom upward so that the highest set bit is written last
   always_comb begin
      code_o = CODE_MAX;
      for (int i = 0; i < DATA_W; i++) begin
         if (srch[i])
            code_o = CODE_W'(DATA_W - 1 - i);
      end
   end

   always_comb begin
      // R6: a set top bit needs no shift at all
      p_top_zero_r6: assert (!srch[DATA_W-1] || code_o == '0)
         else $error("p_top_zero_r6");
      // R7: the largest code means nothing is set above bit 0
      p_max_clear_r7: assert (code_o != CODE_MAX || srch[DATA_W-1:1] == '0)
         else $error("p_max_clear_r7");
   end

endmodule

// File: rtl/bsn_rotator.sv
module bsn_rotator #(
   parameter int DATA_W    = 32,
   parameter int CODE_W    = 5,
   parameter int ROT_STYLE = 0   // 0 = logarithmic stages, 1 = per-bit index mux
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic [CODE_W-1:0] amt_i,
   output logic [DATA_W-1:0] rot_o
);

   if ((1 << CODE_W) != DATA_W) begin : g_bad_width
      $error("bsn_rotator: DATA_W must equal 2**CODE_W");
   end
   if (ROT_STYLE != 0 && ROT_STYLE != 1) begin : g_bad_style
      $error("bsn_rotator: ROT_STYLE must be 0 or 1");
   end

   if (ROT_STYLE == 0) begin : g_log
      logic [CODE_W:0][DATA_W-1:0] stg;
      assign stg[0] = data_i;
      for (genvar s = 0; s < CODE_W; s++) begin : g_stage
         localparam int DIST = 1 << s;
         logic [DATA_W-1:0] turned;
         assign turned     = {stg[s][DATA_W-1-DIST:0], stg[s][DATA_W-1:DATA_W-DIST]};
         assign stg[s + 1] = amt_i[s] ? turned : stg[s];
      end
      assign rot_o = stg[CODE_W];
   end else begin : g_flat
      for (genvar j = 0; j < DATA_W; j++) begin : g_bit
         logic [CODE_W-1:0] src;
         assign src      = CODE_W'(j) - amt_i;
         assign rot_o[j] = data_i[src];
      end
   end

   always_comb begin
      // R1: a rotation keeps every bit of the word
      p_keep_ones_r1: assert ($countones(rot_o) == $countones(data_i))
         else $error("p_keep_ones_r1");
   end

endmodule

// File: rtl/bsn_fill_stage.sv
module bsn_fill_stage
   import bsn_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CODE_W = 5
) (
   input  logic [DATA_W-1:0] rot_i,
   input  logic [CODE_W-1:0] amt_i,
   input  shift_fmt_e        fmt_i,
   input  logic              sign_i,
   output logic [DATA_W-1:0] res_o
);

   if ((1 << CODE_W) != DATA_W) begin : g_bad_width
      $error("bsn_fill_stage: DATA_W must equal 2**CODE_W");
   end

   logic fill_bit;

   // R8: sign reaches the array only as the value for right-shift vacancies
   assign fill_bit = (fmt_i == FMT_RIGHT) ? sign_i : 1'b0;

   // Once the word is rotated left by amt, a left shift has vacated the bits
   // below amt. A right shift by DATA_W-amt has vacated the bits at amt and above.
   for (genvar j = 0; j < DATA_W; j++) begin : g_pos
      localparam logic [CODE_W-1:0] POS = CODE_W'(j);
      logic keep;
      always_comb begin
         unique case (fmt_i)
            FMT_LEFT:  keep = (POS >= amt_i);
            FMT_RIGHT: keep = (POS <  amt_i);
            default:   keep = 1'b1;
         endcase
      end
      assign res_o[j] = keep ? rot_i[j] : fill_bit;
   end

endmodule

// File: rtl/bsn_shift_norm.sv
module bsn_shift_norm
   import bsn_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int ROT_STYLE = 0,
   localparam int CODE_W   = $clog2(DATA_W),
   localparam int OUT_W    = DATA_W / 2
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic              sign_i,
   input  logic [CODE_W-1:0] shamt_i,
   input  logic              dir_right_i,
   input  logic              fill_en_i,
   input  logic              norm_i,
   input  logic              upper_sel_i,
   input  logic              out_en_i,
   output logic [OUT_W-1:0]  y_o,
   output logic [CODE_W-1:0] lead_code_o
);

   if (DATA_W < 4 || (1 << CODE_W) != DATA_W) begin : g_bad_width
      $error("bsn_shift_norm: DATA_W must be a power of two of at least 4");
   end

   logic [CODE_W-1:0] amt;
   logic [DATA_W-1:0] rot;
   logic [DATA_W-1:0] res;
   logic [OUT_W-1:0]  half;
   shift_fmt_e        fmt;

   bsn_lead_enc #(
      .DATA_W (DATA_W),
      .CODE_W (CODE_W)
   ) u_enc (
      .data_i (data_i),
      .sign_i (sign_i),
      .code_o (lead_code_o)
   );

   // R9: normalize routes the encoder code into the array
   assign amt = norm_i ? lead_code_o : shamt_i;
   assign fmt = fmt_of(fill_en_i, dir_right_i);

   bsn_rotator #(
      .DATA_W    (DATA_W),
      .CODE_W    (CODE_W),
      .ROT_STYLE (ROT_STYLE)
   ) u_rot (
      .data_i (data_i),
      .amt_i  (amt),
      .rot_o  (rot)
   );

   bsn_fill_stage #(
      .DATA_W (DATA_W),
      .CODE_W (CODE_W)
   ) u_fill (
      .rot_i  (rot),
      .amt_i  (amt),
      .fmt_i  (fmt),
      .sign_i (sign_i),
      .res_o  (res)
   );

   // R5: half select
   assign half = upper_sel_i ? res[DATA_W-1:OUT_W] : res[OUT_W-1:0];
   // R10: disabled outputs read as zero
   assign y_o  = out_en_i ? half : '0;

   always_comb begin
      // R3: the longest left shift leaves only input bit 0 at the top
      p_left_max_r3: assert (!(fmt == FMT_LEFT && amt == CODE_W'(DATA_W - 1)) ||
                             (res[DATA_W-1] == data_i[0] && res[DATA_W-2:0] == '0))
         else $error("p_left_max_r3");
      // R4: a right shift by the full width gives only sign bits
      p_right_full_r4: assert (!(fmt == FMT_RIGHT && amt == '0) || res == {DATA_W{sign_i}})
         else $error("p_right_full_r4");
      // R9: a normalized nonzero word has its leading digit at the top
      p_norm_lead_r9: assert (!(norm_i && fmt == FMT_LEFT &&
                                (data_i ^ {DATA_W{sign_i}}) != '0) ||
                              res[DATA_W-1] == !sign_i)
         else $error("p_norm_lead_r9");
   end

endmodule

// File: tb/bsn_shift_norm_bench.sv
module bsn_shift_norm_bench;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // Narrow copy, swept exhaustively
   logic [7:0] d8;
   logic       s8, dir8, fill8, norm8, hi8, oe8;
   logic [2:0] c8;
   logic [3:0] y8;
   logic [2:0] e8;

   bsn_shift_norm #(.DATA_W(8), .ROT_STYLE(1)) u_bsn_shift_norm (
      .data_i (d8), .sign_i (s8), .shamt_i (c8), .dir_right_i (dir8),
      .fill_en_i (fill8), .norm_i (norm8), .upper_sel_i (hi8), .out_en_i (oe8),
      .y_o (y8), .lead_code_o (e8)
   );

   // Default-width copy, directed vectors
   logic [31:0] d32;
   logic        s32, dir32, fill32, norm32, hi32, oe32;
   logic [4:0]  c32;
   logic [15:0] y32;
   logic [4:0]  e32;

   bsn_shift_norm u_bsn_shift_norm_w32 (
      .data_i (d32), .sign_i (s32), .shamt_i (c32), .dir_right_i (dir32),
      .fill_en_i (fill32), .norm_i (norm32), .upper_sel_i (hi32), .out_en_i (oe32),
      .y_o (y32), .lead_code_o (e32)
   );

   function automatic logic [63:0] ref_enc(int w, logic [63:0] data, logic sgn);
      logic [63:0] x;
      x = data ^ (sgn ? ((64'd1 << w) - 1) : 64'd0);
      for (int i = w - 1; i >= 0; i--)
         if (x[i]) return 64'(w - 1 - i);
      return 64'(w - 1);
   endfunction

   function automatic logic [63:0] ref_res(int w, logic [63:0] data, logic sgn,
                                           int amt, logic fill, logic dir);
      logic [63:0] mask, ext;
      mask = (64'd1 << w) - 1;
      if (!fill)
         return ((data << amt) | (data >> (w - amt))) & mask;
      else if (!dir)
         return (data << amt) & mask;
      ext = data | (sgn ? (~64'd0 << w) : 64'd0);
      return (ext >> (w - amt)) & mask;
   endfunction

   function automatic logic [63:0] ref_y(int w, logic [63:0] r, logic hi, logic oe);
      int h;
      h = w / 2;
      if (!oe) return 64'd0;
      return (hi ? (r >> h) : r) & ((64'd1 << h) - 1);
   endfunction

   task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic drv32(logic [31:0] d, logic s, logic [4:0] c, logic dir, logic fill,
                        logic norm, logic hi, logic oe);
      d32 = d; s32 = s; c32 = c; dir32 = dir; fill32 = fill;
      norm32 = norm; hi32 = hi; oe32 = oe;
      #5;
   endtask

   initial begin
      d8 = '0; s8 = 0; c8 = '0; dir8 = 0; fill8 = 0; norm8 = 0; hi8 = 0; oe8 = 0;
      d32 = '0; s32 = 0; c32 = '0; dir32 = 0; fill32 = 0; norm32 = 0; hi32 = 0; oe32 = 0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // Reset state: all inputs low, output disabled
      check("R10", "reset y", 64'(y32), 64'd0);
      check("R7", "reset code", 64'(e32), 64'd31);

      // R1: code 1 moves bit 31 to bit 0
      drv32(32'h8000_0001, 0, 5'd1, 0, 0, 0, 0, 1);
      check("R1", "rotate by 1", 64'(y32), 64'h0003);
      // R1: all-ones code rotates right by one
      drv32(32'h0000_0001, 0, 5'd31, 0, 0, 0, 1, 1);
      check("R1", "rotate by 31", 64'(y32), 64'h8000);
      // R2: direction ignored in wrap mode
      drv32(32'h0000_0001, 0, 5'd31, 1, 0, 0, 1, 1);
      check("R2", "wrap dir high", 64'(y32), 64'h8000);
      // R3 and R5: left fill, both halves
      drv32(32'hFFFF_FFFF, 1, 5'd16, 0, 1, 0, 0, 1);
      check("R3", "left 16 lower", 64'(y32), 64'h0000);
      drv32(32'hFFFF_FFFF, 1, 5'd16, 0, 1, 0, 1, 1);
      check("R5", "left 16 upper", 64'(y32), 64'hFFFF);
      // R4: code 0 with direction high is full sign fill
      drv32(32'h1234_5678, 1, 5'd0, 1, 1, 0, 0, 1);
      check("R4", "right 32 lower", 64'(y32), 64'hFFFF);
      drv32(32'h8000_0000, 0, 5'd31, 1, 1, 0, 1, 1);
      check("R4", "right 1 upper", 64'(y32), 64'h4000);
      // R6: encoder codes
      drv32(32'h8000_0000, 0, 5'd0, 0, 0, 0, 0, 1);
      check("R6", "top bit code", 64'(e32), 64'd0);
      drv32(32'h0000_8000, 0, 5'd0, 0, 0, 0, 0, 1);
      check("R6", "bit 15 code", 64'(e32), 64'd16);
      drv32(32'h0000_0001, 0, 5'd0, 0, 0, 0, 0, 1);
      check("R6", "bit 0 code", 64'(e32), 64'd31);
      // R7: all-zero encoder input in both polarities
      drv32(32'h0000_0000, 0, 5'd0, 0, 0, 0, 0, 1);
      check("R7", "zero word", 64'(e32), 64'd31);
      drv32(32'hFFFF_FFFF, 1, 5'd0, 0, 0, 0, 0, 1);
      check("R7", "all ones negative", 64'(e32), 64'd31);
      // R8: sign does not invert the array data
      drv32(32'h0000_FFFF, 1, 5'd0, 0, 0, 0, 0, 1);
      check("R8", "raw data lower", 64'(y32), 64'hFFFF);
      drv32(32'h0000_FFFF, 1, 5'd0, 0, 0, 0, 1, 1);
      check("R8", "raw data upper", 64'(y32), 64'h0000);
      // R9: single-pass normalization
      drv32(32'h0000_0300, 0, 5'd3, 0, 1, 1, 1, 1);
      check("R9", "normalize upper", 64'(y32), 64'hC000);
      check("R9", "normalize code", 64'(e32), 64'd22);
      // R10: disabled output, encoder still valid
      drv32(32'h0000_8000, 0, 5'd0, 0, 0, 0, 0, 0);
      check("R10", "disabled y", 64'(y32), 64'd0);
      check("R10", "disabled code", 64'(e32), 64'd16);

      // Exhaustive sweep of the 8-bit copy
      for (int d = 0; d < 256; d++) begin
         for (int c = 0; c < 512; c++) begin
            logic [63:0] ec, rr, ey;
            string       tag;
            d8 = 8'(d); s8 = c[0]; c8 = 3'(c >> 1); dir8 = c[4]; fill8 = c[5];
            norm8 = c[6]; hi8 = c[7]; oe8 = c[8];
            #2;
            ec = ref_enc(8, 64'(d8), s8);
            rr = ref_res(8, 64'(d8), s8, norm8 ? int'(ec) : int'(c8), fill8, dir8);
            ey = ref_y(8, rr, hi8, oe8);
            if (!oe8)       tag = "R10";
            else if (norm8) tag = "R9";
            else if (!fill8) tag = "R1";
            else if (dir8)  tag = "R4";
            else            tag = "R3";
            check(tag, "sweep y", 64'(y8), ey);
            check((ec == 64'd7 && ((d8 ^ {8{s8}}) == 8'd0)) ? "R7" : "R6",
                  "sweep code", 64'(e8), ec);
         end
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule